// File: doc/BRIEF.md
# Configurable Up/Down Event Counter

This block is a 16-bit counter that advances on events rather than on the clock. An event is either a chosen edge of an asynchronous external input, which is synchronized and edge-detected inside the block, or a pulse from an internal source that is already in the clock domain. A single-byte configuration register sets several things. It sets the operating mode, which edge is counted and whether the count direction comes from a register flag or from the level of a pin. It also sets whether the counter reloads from a programmed value or simply rolls over when it passes its end, and whether a wrap toggles a pulse output.

Software programs the counter through a small write port with four addresses: configuration, reload value, control (run and direction), and interrupt clear. Each underflow or overflow raises a sticky interrupt flag. When pulse output is enabled, the same event also toggles the output pin and drives its output enable. The current count is presented on an output so that the surrounding logic can read it.

Top module: `evt_counter_top`

## Requirements
- R1: After reset, count_o is 0000h, wrap_irq_o is 0, pulse_o is 0 and pulse_oe_o is 0.
- R2: The counter changes on an event only while the configuration operating-mode field (bits 1:0 at address 0) equals 01b and the run bit (bit 0 at address 2) is 1; in all other cases events are ignored.
- R3: With the internal-source bit (configuration bit 7) at 0, configuration bit 3 selects the counted edge of evt_i: 1 counts rising edges and 0 counts falling edges, and the opposite edge is ignored. The count changes on the third rising clock edge after evt_i changes.
- R4: With configuration bit 7 at 1, every clock cycle in which int_src_i is high counts once, regardless of bit 3, and evt_i edges are ignored.
- R5: With configuration bit 4 at 0, the direction is taken from control bit 1 (1 up, 0 down). With bit 4 at 1, it is taken from dir_pin_i (high up, low down).
- R6: In reload type (configuration bit 6 at 0), a down count from 0000h or an up count from FFFFh loads the reload value in place of wrapping.
- R7: In free-run type (configuration bit 6 at 1), a down count from 0000h gives FFFFh and an up count from FFFFh gives 0000h.
- R8: Every underflow or overflow sets wrap_irq_o, which stays set until a write to address 3 clears it.
- R9: With configuration bit 2 at 1, pulse_oe_o is 1 and pulse_o toggles on each underflow or overflow. With bit 2 at 0, pulse_oe_o and pulse_o are 0.
- R10: When the direction comes from the pin (configuration bit 4 at 1), pulse_oe_o is 0, so the pin is left as an input.
- R11: A write to the reload value (address 1) while the run bit is 0 also loads the counter; while the run bit is 1 it changes only the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 configuration, 1 reload, 2 control, 3 interrupt clear |
| wr_data_i | input | 16 | Write data |
| evt_i | input | 1 | Asynchronous external event input |
| int_src_i | input | 1 | Internal count source pulse, synchronous |
| dir_pin_i | input | 1 | Level sensed on the output pin, used as direction |
| count_o | output | 16 | Current counter value |
| wrap_irq_o | output | 1 | Sticky underflow/overflow interrupt flag |
| pulse_o | output | 1 | Pulse output level (0 while not driven) |
| pulse_oe_o | output | 1 | Output enable for the pulse pin |

## Verification
The assertions check on every cycle that the count holds while the block is disabled, that a wrap lands on the reload value or on the rollover value, that the interrupt flag stays set until it is cleared, that the pulse toggles on each wrap, that the pulse is low whenever its enable is low, and that a detected edge lasts a single cycle. Only the bench scenarios can show which edge is counted, the synchronizer latency, the direction taken from the flag or from the pin, the loading of the reload value while stopped versus while running, and the exact values across underflow and overflow.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;

  localparam int unsigned CNT_W = 16;

  localparam logic [1:0] ADDR_CFG    = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_CLR    = 2'd3;

  localparam logic [1:0] OPMODE_EVENT = 2'b01;

  // Configuration byte, most significant field first.
  typedef struct packed {
    logic       src_int;    // bit 7: count internal source pulses
    logic       free_run;   // bit 6: roll over instead of reload
    logic       rsvd;       // bit 5: kept at 0
    logic       dir_pin;    // bit 4: direction from pin level
    logic       edge_rise;  // bit 3: count rising edges
    logic       pulse_en;   // bit 2: drive pulse output
    logic [1:0] opmode;     // bits 1:0: operating mode
  } cfg_t;

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;

  // R3: a detected edge lasts exactly one cycle
  a_r3_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r3_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_counter_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output cfg_t         cfg_o,
  output logic [W-1:0] reload_o,
  output logic         run_o,
  output logic         up_flag_o,
  output logic         reload_wr_o,
  output logic [W-1:0] load_val_o,
  output logic         irq_clr_o
);

  cfg_t         cfg_q, cfg_d;
  logic [W-1:0] reload_q, reload_d;
  logic         run_q, run_d;
  logic         up_q, up_d;
  logic         cfg_we, reload_we, ctrl_we;

  assign cfg_we    = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign reload_we = wr_en_i && (wr_addr_i == ADDR_RELOAD);
  assign ctrl_we   = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_comb begin
    cfg_d    = cfg_q;
    reload_d = reload_q;
    run_d    = run_q;
    up_d     = up_q;
    if (cfg_we) begin
      cfg_d      = cfg_t'(wr_data_i[7:0]);
      cfg_d.rsvd = 1'b0;
    end
    if (reload_we) reload_d = wr_data_i;
    if (ctrl_we) begin
      run_d = wr_data_i[0];
      up_d  = wr_data_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      up_q     <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      reload_q <= reload_d;
      run_q    <= run_d;
      up_q     <= up_d;
    end
  end

  assign cfg_o       = cfg_q;
  assign reload_o    = reload_q;
  assign run_o       = run_q;
  assign up_flag_o   = up_q;
  assign reload_wr_o = reload_we;
  assign load_val_o  = wr_data_i;
  assign irq_clr_o   = wr_en_i && (wr_addr_i == ADDR_CLR);

endmodule

// File: rtl/evt_core.sv
module evt_core
  import evt_counter_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cfg_t         cfg_i,
  input  logic [W-1:0] reload_i,
  input  logic         run_i,
  input  logic         up_flag_i,
  input  logic         dir_pin_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         int_src_i,
  input  logic         reload_wr_i,
  input  logic [W-1:0] load_val_i,
  input  logic         irq_clr_i,
  output logic [W-1:0] count_o,
  output logic         irq_o,
  output logic         pulse_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_MIN = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic         irq_q, irq_d;
  logic         pls_q, pls_d;
  logic         active, hit, step, up, wrap, direct_load;

  always_comb begin
    active      = run_i && (cfg_i.opmode == OPMODE_EVENT);
    if (cfg_i.src_int) hit = int_src_i;
    else               hit = cfg_i.edge_rise ? rise_i : fall_i;
    step        = active && hit;
    up          = cfg_i.dir_pin ? dir_pin_i : up_flag_i;
    wrap        = step && (up ? (cnt_q == CNT_MAX) : (cnt_q == CNT_MIN));
    direct_load = reload_wr_i && !run_i;

    cnt_d = cnt_q;
    if (direct_load) begin
      cnt_d = load_val_i;
    end else if (wrap) begin
      if (cfg_i.free_run) cnt_d = up ? CNT_MIN : CNT_MAX;
      else                cnt_d = reload_i;
    end else if (step) begin
      cnt_d = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end

    irq_d = wrap | (irq_q & ~irq_clr_i);
    pls_d = pls_q ^ (wrap & cfg_i.pulse_en);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      pls_q <= pls_d;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;
  assign pulse_o = pls_q;

  // R2: no event outside event mode or while stopped moves the count
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !direct_load) |=> $stable(cnt_q));
  // R6: reload type lands on the reload value after a wrap
  a_r6_reload_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !cfg_i.free_run && !direct_load) |=> (cnt_q == $past(reload_i)));
  // R7: free-run overflow lands on zero
  a_r7_free_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && cfg_i.free_run && up && !direct_load) |=> (cnt_q == CNT_MIN));
  // R8: the interrupt flag stays set until cleared
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  // R9: an enabled pulse toggles on each wrap
  a_r9_pulse_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && cfg_i.pulse_en) |=> (pls_q != $past(pls_q)));

endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
  import evt_counter_pkg::*;
#(
  parameter int unsigned W           = CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         evt_i,
  input  logic         int_src_i,
  input  logic         dir_pin_i,
  output logic [W-1:0] count_o,
  output logic         wrap_irq_o,
  output logic         pulse_o,
  output logic         pulse_oe_o
);

  logic [1:0]   rst_pipe_q;
  logic         rst_n;
  cfg_t         cfg;
  logic [W-1:0] reload, load_val;
  logic         run, up_flag, reload_wr, irq_clr;
  logic         rise, fall, pls;

  // Reset asserts at once and leaves after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (evt_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  evt_regs #(.W(W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .cfg_o       (cfg),
    .reload_o    (reload),
    .run_o       (run),
    .up_flag_o   (up_flag),
    .reload_wr_o (reload_wr),
    .load_val_o  (load_val),
    .irq_clr_o   (irq_clr)
  );

  evt_core #(.W(W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .cfg_i       (cfg),
    .reload_i    (reload),
    .run_i       (run),
    .up_flag_i   (up_flag),
    .dir_pin_i   (dir_pin_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .int_src_i   (int_src_i),
    .reload_wr_i (reload_wr),
    .load_val_i  (load_val),
    .irq_clr_i   (irq_clr),
    .count_o     (count_o),
    .irq_o       (wrap_irq_o),
    .pulse_o     (pls)
  );

  // The pin is driven only when pulse output is on and not sensed for direction.
  assign pulse_oe_o = cfg.pulse_en & ~cfg.dir_pin;
  assign pulse_o    = pls & pulse_oe_o;

  // R9: an undriven pin shows no pulse level
  a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pulse_oe_o |-> !pulse_o);
  // R10: a direction taken from the pin keeps the output disabled
  a_r10_pin_input: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg.dir_pin && up_flag !== 1'bx) |-> !pulse_oe_o);

endmodule

// File: tb/evt_counter_top_test.sv
module evt_counter_top_test;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [1:0]  wr_addr_i;
  logic [15:0] wr_data_i;
  logic        evt_i, int_src_i, dir_pin_i;
  logic [15:0] count_o;
  logic        wrap_irq_o, pulse_o, pulse_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  evt_counter_top uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .evt_i      (evt_i),
    .int_src_i  (int_src_i),
    .dir_pin_i  (dir_pin_i),
    .count_o    (count_o),
    .wrap_irq_o (wrap_irq_o),
    .pulse_o    (pulse_o),
    .pulse_oe_o (pulse_oe_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // Change evt_i and wait until the third clock edge has passed.
  task automatic evt_set(input logic v);
    @(negedge clk_i);
    evt_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic src_pulses(input int n);
    @(negedge clk_i);
    int_src_i = 1'b1;
    repeat (n) @(negedge clk_i);
    int_src_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", count_o, 16'h0000);
    chk("R1 irq", {15'b0, wrap_irq_o}, 16'h0);
    chk("R1 pulse", {15'b0, pulse_o}, 16'h0);
    chk("R1 oe", {15'b0, pulse_oe_o}, 16'h0);
  endtask

  task automatic t_gate_and_edges;
    wr(2'd1, 16'h0005);
    chk("R11 stopped load", count_o, 16'h0005);
    wr(2'd0, 16'h0008);       // mode field 00, rising
    wr(2'd2, 16'h0003);       // run, up
    evt_set(1'b1);
    chk("R2 wrong mode", count_o, 16'h0005);
    evt_set(1'b0);
    wr(2'd0, 16'h0009);       // event mode, rising
    evt_set(1'b1);
    chk("R3 rising counted", count_o, 16'h0006);
    evt_set(1'b0);
    chk("R3 falling ignored", count_o, 16'h0006);
    wr(2'd2, 16'h0002);       // stopped
    evt_set(1'b1);
    chk("R2 stopped", count_o, 16'h0006);
    wr(2'd0, 16'h0001);       // falling edges
    wr(2'd2, 16'h0003);
    evt_set(1'b0);
    chk("R3 falling counted", count_o, 16'h0007);
    evt_set(1'b1);
    chk("R3 rising ignored", count_o, 16'h0007);
  endtask

  task automatic t_direction;
    wr(2'd0, 16'h0081);       // internal source
    wr(2'd2, 16'h0001);       // run, down
    src_pulses(3);
    chk("R4 R5 down by flag", count_o, 16'h0004);
    evt_set(1'b0);
    chk("R4 pin edge ignored", count_o, 16'h0004);
    wr(2'd0, 16'h0095);       // direction from pin, pulse enable requested
    chk("R10 oe off", {15'b0, pulse_oe_o}, 16'h0);
    dir_pin_i = 1'b1;
    src_pulses(2);
    chk("R5 pin high up", count_o, 16'h0006);
    dir_pin_i = 1'b0;
    src_pulses(1);
    chk("R5 pin low down", count_o, 16'h0005);
  endtask

  task automatic t_reload;
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0002);
    chk("R11 load", count_o, 16'h0002);
    wr(2'd0, 16'h0085);       // internal, pulse on, reload type
    wr(2'd2, 16'h0001);
    chk("R9 oe on", {15'b0, pulse_oe_o}, 16'h1);
    src_pulses(2);
    chk("R6 at zero", count_o, 16'h0000);
    chk("R8 no irq yet", {15'b0, wrap_irq_o}, 16'h0);
    src_pulses(1);
    chk("R6 underflow reload", count_o, 16'h0002);
    chk("R8 irq set", {15'b0, wrap_irq_o}, 16'h1);
    chk("R9 pulse high", {15'b0, pulse_o}, 16'h1);
    wr(2'd1, 16'h0010);
    chk("R11 running no load", count_o, 16'h0002);
    wr(2'd3, 16'h0000);
    chk("R8 cleared", {15'b0, wrap_irq_o}, 16'h0);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'h0003);
    src_pulses(2);
    chk("R6 overflow reload", count_o, 16'hFFFE);
    chk("R8 irq overflow", {15'b0, wrap_irq_o}, 16'h1);
    chk("R9 pulse toggled back", {15'b0, pulse_o}, 16'h0);
  endtask

  task automatic t_free_run;
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h00C1);       // internal, free-run, no pulse
    chk("R9 oe off", {15'b0, pulse_oe_o}, 16'h0);
    wr(2'd2, 16'h0001);
    src_pulses(2);
    chk("R7 underflow", count_o, 16'hFFFF);
    chk("R8 irq free", {15'b0, wrap_irq_o}, 16'h1);
    chk("R9 pulse idle", {15'b0, pulse_o}, 16'h0);
    wr(2'd2, 16'h0003);
    src_pulses(1);
    chk("R7 overflow", count_o, 16'h0000);
    chk("R8 still set", {15'b0, wrap_irq_o}, 16'h1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    evt_i = 1'b0; int_src_i = 1'b0; dir_pin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_gate_and_edges();
    t_direction();
    t_reload();
    t_free_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule